// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier with Carry-Select Accumulation

This block multiplies two unsigned operands, one multiplier bit per clock. A single-cycle start strobe captures both operands. The multiplicand goes into a holding register. The multiplier goes into the low half of a combined result register that is one bit wider than the product.

On each of the following cycles the controller looks at the least significant bit of that register. When the bit is set, the stored multiplicand is added into the upper half. When it is clear, nothing is added. In both cases the register then shifts right by one place, and the adder carry enters just below the top bit.

The adder is split into segments. Every segment above the lowest one computes its sum for both possible carry-ins at once, and the incoming carry picks one of the two results. A one-cycle done flag marks the point where the full product is on the output.

Top module: `seq_csel_mul`

## Requirements
- R1: While reset is held and right after it is released, done_o is 0 and product_o is 0.
- R2: The multiplicand is captured only on a start_i that is accepted in the idle state. Changes to a_i at any other time have no effect on the result.
- R3: On the clock edge that accepts start_i, the upper W+1 bits of the result register are cleared and the low W bits take b_i. On the next cycle, product_o therefore equals b_i zero-extended.
- R4: After k iterations (k = 1..W), product_o equals (a × (b mod 2^k)) × 2^(W−k) + (b >> k). A multiplier bit of 0 only shifts the register and adds nothing.
- R5: done_o is high for exactly one cycle, starting W clock edges after the edge that accepts start_i.
- R6: While done_o is high, product_o equals a × b as unsigned 2W-bit values, for every operand pair.
- R7: A start_i that arrives while a multiplication is in progress or while done_o is high is ignored. The operation in progress keeps its operands and its timing.
- R8: The segmented carry-select adder gives the exact W-bit sum and carry of the upper register half plus the multiplicand, including carries that cross segment boundaries.
- R9: After done_o falls, product_o keeps a × b until the next accepted start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| a_i | input | W (8) | Multiplicand operand |
| b_i | input | W (8) | Multiplier operand |
| product_o | output | 2W (16) | Low 2W bits of the result register |
| done_o | output | 1 | One-cycle completion flag |

## Verification
Every multiplicand is paired with sixteen chosen multiplier values, and every multiplier is paired with the same sixteen multiplicand values. The chosen values are zero, one, all ones, single-bit, nibble-boundary and alternating-bit patterns. Zero and sparse multipliers exercise the shift-only path. All-ones operands force carries through every adder segment and into the carry bit of the register. Alternating patterns make the add and skip cycles interleave.

The partial result is compared on every cycle, so an error in the ordering of add and shift shows up even when the final product happens to be correct. A second pass toggles the operands and holds start high during the operation, which separates correct operand capture from late sampling.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_rca.sv
module mul_rca #(
  parameter int N = 4
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  input  logic         cin_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  logic [N:0] c;
  assign c[0] = cin_i;
  for (genvar i = 0; i < N; i++) begin : g_fa
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    assign c[i+1]   = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
  end
  assign cout_o = c[N];
endmodule

// File: rtl/mul_csel_add.sv
module mul_csel_add #(
  parameter int W   = 8,
  parameter int SEG = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int NSEG = W / SEG;
  logic [NSEG:0] c;
  assign c[0] = cin_i;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    if (s == 0) begin : g_low
      mul_rca #(.N(SEG)) u_rca (
        .a_i(a_i[SEG-1:0]), .b_i(b_i[SEG-1:0]), .cin_i(c[0]),
        .sum_o(sum_o[SEG-1:0]), .cout_o(c[1]));
    end else begin : g_hi
      logic [SEG-1:0] s0, s1;
      logic           c0, c1;
      // both carry-in cases precomputed, selected by incoming carry
      mul_rca #(.N(SEG)) u_rca0 (
        .a_i(a_i[s*SEG +: SEG]), .b_i(b_i[s*SEG +: SEG]), .cin_i(1'b0),
        .sum_o(s0), .cout_o(c0));
      mul_rca #(.N(SEG)) u_rca1 (
        .a_i(a_i[s*SEG +: SEG]), .b_i(b_i[s*SEG +: SEG]), .cin_i(1'b1),
        .sum_o(s1), .cout_o(c1));
      assign sum_o[s*SEG +: SEG] = c[s] ? s1 : s0;
      assign c[s+1]              = c[s] ? c1 : c0;
    end
  end
  assign cout_o = c[NSEG];
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic run_o,
  output logic done_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mul_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RUN;
      ST_RUN:  if (cnt_q == LAST) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN) cnt_q <= cnt_q + 1'b1;
      else                   cnt_q <= '0;
    end
  end

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign run_o  = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);

  // R7: run advances one step per cycle regardless of start_i
  assert_run_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q != LAST) |=>
      (state_q == ST_RUN && cnt_q == $past(cnt_q) + 1'b1));
  assert_run_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && cnt_q == LAST) |=> done_o);
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int W   = 8,
  parameter int SEG = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           run_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  localparam int RW = 2 * W + 1;

  logic [W-1:0]  mcand_q;
  logic [RW-1:0] res_q;
  logic [W-1:0]  addend, add_sum;
  logic          add_co;

  // deletion: zero multiplier bit contributes no partial product
  assign addend = res_q[0] ? mcand_q : '0;

  mul_csel_add #(.W(W), .SEG(SEG)) u_add (
    .a_i(res_q[2*W-1:W]), .b_i(addend), .cin_i(1'b0),
    .sum_o(add_sum), .cout_o(add_co));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      res_q   <= '0;
    end else if (load_i) begin
      mcand_q <= a_i;
      res_q   <= {{(W+1){1'b0}}, b_i};
    end else if (run_i) begin
      res_q   <= {1'b0, add_co, add_sum, res_q[W-1:1]};
    end
  end

  assign prod_o = res_q[2*W-1:0];

  assert_mcand_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mcand_q));
  assert_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> res_q == {{(W+1){1'b0}}, $past(b_i)});
  assert_skip_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !res_q[0]) |=> res_q == {1'b0, $past(res_q[RW-1:1])});
  assert_add_exact_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && res_q[0]) |->
      {add_co, add_sum} == ({1'b0, res_q[2*W-1:W]} + {1'b0, mcand_q}));
endmodule

// File: rtl/seq_csel_mul.sv
module seq_csel_mul #(
  parameter int W   = 8,
  parameter int SEG = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] product_o,
  output logic           done_o
);
  logic load, run;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .load_o(load), .run_o(run), .done_o(done_o));

  mul_datapath #(.W(W), .SEG(SEG)) u_dp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .run_i(run),
    .a_i(a_i), .b_i(b_i), .prod_o(product_o));

  // R9: result holds while idle after completion
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && !run) |=> $stable(product_o));
endmodule

// File: tb/seq_csel_mul_bench.sv
module seq_csel_mul_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  a = '0, b = '0;
  logic [15:0] product;
  logic        done;
  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  seq_csel_mul u_seq_csel_mul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .a_i(a), .b_i(b), .product_o(product), .done_o(done));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // partial result after k steps, from the shift-add definition
  function automatic int model(input int av, input int bv, input int k);
    return ((av * (bv & ((1 << k) - 1))) << (8 - k)) | (bv >> k);
  endfunction

  task automatic run_op(input int av, input int bv, input bit perturb);
    @(negedge clk);
    start = 1'b1; a = 8'(av); b = 8'(bv);
    @(negedge clk);
    start = 1'b0;
    check(product == 16'(bv), "R3", int'(product), bv);
    check(done == 1'b0, "R5", int'(done), 0);
    if (perturb) begin
      start = 1'b1; a = ~a; b = ~b; // R7, R2: must be ignored
    end
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check(product == 16'(model(av, bv, k)), (k == 8) ? "R6" : "R4",
            int'(product), model(av, bv, k));
      check(done == (k == 8), "R5", int'(done), int'(k == 8));
      if (k == 8) start = 1'b0;
    end
    @(negedge clk);
    check(done == 1'b0, "R5", int'(done), 0);
    check(product == 16'(av * bv), perturb ? "R7" : "R9", int'(product), av * bv);
  endtask

  initial begin
    int pat[16] = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h10, 8'h55, 8'hAA, 8'h7F,
                    8'h80, 8'hFE, 8'hFF, 8'h33, 8'hCC, 8'h0A, 8'hF0, 8'h99};
    repeat (2) @(negedge clk);
    check(product == 16'h0 && done == 1'b0, "R1", int'(product), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(product == 16'h0 && done == 1'b0, "R1", int'(product), 0);
    for (int p = 0; p < 16; p++)
      for (int v = 0; v < 256; v++) begin
        run_op(v, pat[p], 1'b0);
        run_op(pat[p], v, 1'b0);
      end
    // R8: carries through every segment under late operand changes
    for (int p = 0; p < 16; p++) run_op(pat[p], 8'hFF - pat[p], 1'b1);
    run_op(8'hFF, 8'hFF, 1'b1);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule